// File: doc/BRIEF.md
# Scan-Path Register Bridge

This block hangs off one user instruction of a test access port and turns the data-register scan path into a small register bus. A host shifts short framed commands through the scan chain: a long frame carries a 32-bit value and writes it into one of sixteen addressed registers, while a short frame names a register whose contents are then returned on the next data-register scan. Every frame is protected by a single odd-parity bit, and frames that are malformed or have a length the bridge does not expect are dropped without side effects.

The addressed space holds eight work-state words (addresses 1 to 8), three trailing work words (addresses 9 to 11), a clock control word (address 13) and a read-only result port (address 14). The result port drains a 16-entry queue of 32-bit results pushed by the compute core; reading it while the queue is empty returns all ones. Writing the last trailing word starts a job in the core. The access port controller, clock generator and core sit outside and appear here only as ports, with the scan strobes already synchronised to `clk`.

Top module: `tap_regbridge`

## Requirements
- R1: A 38-bit frame shifted in least significant bit first, with bits 31..0 the data, bits 35..32 the address, bit 36 the write flag set to 1 and bit 37 the parity bit, writes the data into the addressed register when the address is 1..11 or 13; registers 1..8 appear on `midstate_o` (register 1+k at bits 32k+31..32k) and registers 9..11 on `tail_o` (register 9+k at bits 32k+31..32k), register 13 on `clk_ctrl_o`.
- R2: A 6-bit frame with bits 3..0 the address, bit 4 the write flag set to 0 and bit 5 the parity bit selects a register; the next data-register scan of 32 bits presents that register's value on `tap_tdo_o`, least significant bit first, the first bit valid right after the capture strobe.
- R3: A frame is accepted only when the number of ones in it, parity bit included, is odd; a frame with even ones changes no register, starts no job and pops no result.
- R4: A frame is acted on at the update strobe only when exactly 6 bits (with write flag 0) or exactly 38 bits (with write flag 1) were shifted since the last capture strobe; any other count or flag combination is discarded.
- R5: Capture, shift and update strobes have no effect while `tap_sel_i` is low.
- R6: After reset the clock control register holds 200 (twice the default multiplier of 100, i.e. the 200 MHz default), all other registers hold zero and the overflow flag is clear.
- R7: Writes to addresses 0, 12, 14 and 15 have no effect; reads of addresses 0, 12 and 15 return zero.
- R8: A read frame of address 14 pops the oldest queued result and returns it; results come out in push order, and a read with the queue empty returns 32'hFFFF_FFFF.
- R9: The result queue holds 16 entries; a push while full with no pop drops the new result and sets `nonce_ovf_o`, which stays set until reset.
- R10: A push and a pop in the same cycle on a full queue both take effect: the popped entry is returned, the pushed result is kept and the overflow flag does not rise.
- R11: An accepted write to address 11 raises `job_start_o` for exactly one cycle, the cycle after the update strobe; no other frame raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_sel_i | input | 1 | User instruction is selected in the access port |
| tap_capture_i | input | 1 | Capture-DR strobe |
| tap_shift_i | input | 1 | Shift-DR strobe, one bit per cycle |
| tap_update_i | input | 1 | Update-DR strobe |
| tap_tdi_i | input | 1 | Serial data into the scan path |
| tap_tdo_o | output | 1 | Serial data out of the scan path |
| nonce_valid_i | input | 1 | Core pushes a result this cycle |
| nonce_i | input | 32 | Result value from the core |
| midstate_o | output | 256 | Registers 1..8, packed |
| tail_o | output | 96 | Registers 9..11, packed |
| clk_ctrl_o | output | 32 | Clock control register (twice the multiplier) |
| job_start_o | output | 1 | One-cycle job start pulse |
| nonce_ovf_o | output | 1 | Sticky result queue overflow |

## Verification
The result queue can be pushed by the core and popped by a host read of address 14 in the same clock cycle, and the interesting case is when the queue is already full. The bench fills the queue to 16 entries and then asserts the core push exactly in the update-strobe cycle of a read frame of address 14. It judges the outcome by the overflow flag staying low and by the next seventeen reads returning the fifteen remaining entries, then the newly pushed result, then all ones.

// File: rtl/tapbr_pkg.sv
package tapbr_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int NUM_REGS    = 1 << ADDR_W;
    localparam int RD_FRAME_W  = ADDR_W + 2;
    localparam int WR_FRAME_W  = DATA_W + ADDR_W + 2;
    localparam int FLAG_BIT    = DATA_W + ADDR_W;
    localparam int PAR_BIT     = FLAG_BIT + 1;

    localparam int MID_FIRST   = 1;
    localparam int MID_COUNT   = 8;
    localparam int TAIL_FIRST  = MID_FIRST + MID_COUNT;
    localparam int TAIL_COUNT  = 3;
    localparam int JOB_ADDR    = TAIL_FIRST + TAIL_COUNT - 1;
    localparam int CLKCTL_ADDR = 13;
    localparam int RESULT_ADDR = 14;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t addr;
        word_t data;
    } cmd_t;

    // True for addresses backed by a writable storage register.
    function automatic logic is_storage(input int a);
        return ((a >= MID_FIRST) && (a < TAIL_FIRST + TAIL_COUNT)) || (a == CLKCTL_ADDR);
    endfunction

endpackage

// File: rtl/tapbr_shift.sv
module tapbr_shift
    import tapbr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_i,
    input  logic  capture_i,
    input  logic  shift_i,
    input  logic  update_i,
    input  logic  tdi_i,
    input  word_t load_i,
    output logic  tdo_o,
    output cmd_t  cmd_o
);

    localparam int CNT_W = $clog2(WR_FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] RD_LEN  = CNT_W'(RD_FRAME_W);
    localparam logic [CNT_W-1:0] WR_LEN  = CNT_W'(WR_FRAME_W);

    logic [WR_FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]      cnt_q;
    logic                  short_ok;
    logic                  long_ok;

    // Bits enter at the top and move down, so after a full-length
    // frame bit 0 of the frame sits at sr_q[0]; after a short frame
    // its six bits sit at the top, where the long frame keeps its
    // address, flag and parity.
    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (sel_i) begin
            if (capture_i) begin
                sr_q  <= {{(WR_FRAME_W-DATA_W){1'b0}}, load_i};
                cnt_q <= '0;
            end else if (shift_i) begin
                sr_q  <= {tdi_i, sr_q[WR_FRAME_W-1:1]};
                cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        short_ok = (cnt_q == RD_LEN) && !sr_q[FLAG_BIT]
                   && (^sr_q[PAR_BIT -: RD_FRAME_W]);
        long_ok  = (cnt_q == WR_LEN) && sr_q[FLAG_BIT] && (^sr_q);
        cmd_o.valid = sel_i && update_i && (short_ok || long_ok);
        cmd_o.write = long_ok;
        cmd_o.addr  = sr_q[FLAG_BIT-1 -: ADDR_W];
        cmd_o.data  = sr_q[DATA_W-1:0];
    end

    assign tdo_o = sr_q[0];

    // R2: each shift moves the next bit onto the serial output.
    a_r2_tdo_advance: assert property (@(posedge clk) disable iff (rst)
        (sel_i && shift_i && !capture_i) |=> (tdo_o == $past(sr_q[1])));

endmodule

// File: rtl/tapbr_fifo.sv
module tapbr_fifo
    import tapbr_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_i,
    input  word_t data_i,
    input  logic  pop_i,
    output word_t head_o,
    output logic  empty_o,
    output logic  ovf_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    word_t         mem [DEPTH];
    logic [AW-1:0] wr_ptr_q;
    logic [AW-1:0] rd_ptr_q;
    logic [CW-1:0] count_q;
    logic          pop_do;
    logic          push_do;

    assign empty_o = (count_q == '0);
    assign head_o  = mem[rd_ptr_q];
    assign pop_do  = pop_i && !empty_o;
    // A pop in the same cycle frees the slot the push needs.
    assign push_do = push_i && ((count_q != FULL_CNT) || pop_do);

    always_ff @(posedge clk) begin
        if (push_do) begin
            mem[wr_ptr_q] <= data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_o    <= 1'b0;
        end else begin
            if (push_do) begin
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_do) begin
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push_do, pop_do})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
            if (push_i && !push_do) begin
                ovf_o <= 1'b1;
            end
        end
    end

    // R9: occupancy never exceeds the depth.
    a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= FULL_CNT);

    // R9: the overflow flag only clears through reset.
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R10: simultaneous push and pop on a full queue keeps it full, no overflow.
    a_r10_full_swap: assert property (@(posedge clk) disable iff (rst)
        (count_q == FULL_CNT && push_i && pop_i && !ovf_o) |=> (count_q == FULL_CNT && !ovf_o));

    // R8: popping an empty queue leaves it empty.
    a_r8_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty_o && pop_i && !push_i) |=> empty_o);

endmodule

// File: rtl/tapbr_regs.sv
module tapbr_regs
    import tapbr_pkg::*;
#(
    parameter word_t CLK_RESET = 32'd200
) (
    input  logic                          clk,
    input  logic                          rst,
    input  cmd_t                          cmd_i,
    input  word_t                         fifo_head_i,
    input  logic                          fifo_empty_i,
    output logic                          pop_o,
    output word_t                         rd_hold_o,
    output logic [MID_COUNT*DATA_W-1:0]   midstate_o,
    output logic [TAIL_COUNT*DATA_W-1:0]  tail_o,
    output word_t                         clk_ctrl_o,
    output logic                          job_start_o
);

    word_t regs [NUM_REGS];
    logic  rd_req;
    word_t rd_value;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (is_storage(g)) begin : g_store
            word_t q;
            logic  we;
            assign we = cmd_i.valid && cmd_i.write && (cmd_i.addr == ADDR_W'(g));
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= (g == CLKCTL_ADDR) ? CLK_RESET : '0;
                end else if (we) begin
                    q <= cmd_i.data;
                end
            end
            assign regs[g] = q;
        end else begin : g_void
            assign regs[g] = '0;
        end
    end

    for (genvar k = 0; k < MID_COUNT; k++) begin : g_mid
        assign midstate_o[k*DATA_W +: DATA_W] = regs[MID_FIRST + k];
    end

    for (genvar k = 0; k < TAIL_COUNT; k++) begin : g_tail
        assign tail_o[k*DATA_W +: DATA_W] = regs[TAIL_FIRST + k];
    end

    assign clk_ctrl_o = regs[CLKCTL_ADDR];

    assign rd_req = cmd_i.valid && !cmd_i.write;
    assign pop_o  = rd_req && (cmd_i.addr == ADDR_W'(RESULT_ADDR));

    always_comb begin
        if (cmd_i.addr == ADDR_W'(RESULT_ADDR)) begin
            rd_value = fifo_empty_i ? '1 : fifo_head_i;
        end else begin
            rd_value = regs[cmd_i.addr];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold_o   <= '0;
            job_start_o <= 1'b0;
        end else begin
            if (rd_req) begin
                rd_hold_o <= rd_value;
            end
            job_start_o <= cmd_i.valid && cmd_i.write
                           && (cmd_i.addr == ADDR_W'(JOB_ADDR));
        end
    end

    // R11: the job start pulse lasts a single cycle.
    a_r11_job_single: assert property (@(posedge clk) disable iff (rst)
        job_start_o |=> !job_start_o);

    // R6: the clock control word holds unless a write to it is accepted.
    a_r6_clk_hold: assert property (@(posedge clk) disable iff (rst)
        !(cmd_i.valid && cmd_i.write && cmd_i.addr == ADDR_W'(CLKCTL_ADDR))
        |=> $stable(clk_ctrl_o));

endmodule

// File: rtl/tap_regbridge.sv
module tap_regbridge
    import tapbr_pkg::*;
#(
    parameter int    FIFO_DEPTH = 16,
    parameter word_t CLK_RESET  = 32'd200
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tap_sel_i,
    input  logic                          tap_capture_i,
    input  logic                          tap_shift_i,
    input  logic                          tap_update_i,
    input  logic                          tap_tdi_i,
    output logic                          tap_tdo_o,
    input  logic                          nonce_valid_i,
    input  logic [DATA_W-1:0]             nonce_i,
    output logic [MID_COUNT*DATA_W-1:0]   midstate_o,
    output logic [TAIL_COUNT*DATA_W-1:0]  tail_o,
    output logic [DATA_W-1:0]             clk_ctrl_o,
    output logic                          job_start_o,
    output logic                          nonce_ovf_o
);

    cmd_t  cmd;
    word_t rd_hold;
    word_t fifo_head;
    logic  fifo_empty;
    logic  fifo_pop;

    tapbr_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sel_i     (tap_sel_i),
        .capture_i (tap_capture_i),
        .shift_i   (tap_shift_i),
        .update_i  (tap_update_i),
        .tdi_i     (tap_tdi_i),
        .load_i    (rd_hold),
        .tdo_o     (tap_tdo_o),
        .cmd_o     (cmd)
    );

    tapbr_regs #(.CLK_RESET(CLK_RESET)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd),
        .fifo_head_i  (fifo_head),
        .fifo_empty_i (fifo_empty),
        .pop_o        (fifo_pop),
        .rd_hold_o    (rd_hold),
        .midstate_o   (midstate_o),
        .tail_o       (tail_o),
        .clk_ctrl_o   (clk_ctrl_o),
        .job_start_o  (job_start_o)
    );

    tapbr_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push_i  (nonce_valid_i),
        .data_i  (nonce_i),
        .pop_i   (fifo_pop),
        .head_o  (fifo_head),
        .empty_o (fifo_empty),
        .ovf_o   (nonce_ovf_o)
    );

    // R5: with the user instruction deselected no job can start.
    a_r5_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        !tap_sel_i |=> !job_start_o);

endmodule

// File: tb/tap_regbridge_tb.sv
module tap_regbridge_tb;

    logic         clk = 1'b0;
    logic         rst;
    logic         sel, cap, shf, upd, tdi;
    logic         tdo;
    logic         nv;
    logic [31:0]  nd;
    logic [255:0] mid;
    logic [95:0]  tail;
    logic [31:0]  clkc;
    logic         job, ovf;

    int    vecs = 0;
    int    errs = 0;
    logic  last_job;
    logic [31:0] expv [16];

    always #5 clk = ~clk;

    tap_regbridge u_dut (
        .clk(clk), .rst(rst), .tap_sel_i(sel), .tap_capture_i(cap),
        .tap_shift_i(shf), .tap_update_i(upd), .tap_tdi_i(tdi), .tap_tdo_o(tdo),
        .nonce_valid_i(nv), .nonce_i(nd), .midstate_o(mid), .tail_o(tail),
        .clk_ctrl_o(clkc), .job_start_o(job), .nonce_ovf_o(ovf)
    );

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [37:0] wr_frame(input int a, input logic [31:0] d, input bit good);
        logic [37:0] f = '0;
        f[31:0]  = d;
        f[35:32] = a[3:0];
        f[36]    = 1'b1;
        f[37]    = ~(^f[36:0]) ^ !good;
        return f;
    endfunction

    function automatic logic [37:0] rd_frame(input int a, input bit flag, input bit good);
        logic [37:0] f = '0;
        f[3:0] = a[3:0];
        f[4]   = flag;
        f[5]   = ~(^f[4:0]) ^ !good;
        return f;
    endfunction

    // One data-register scan: capture, len shifts, update. Optionally
    // pushes a result in the update cycle.
    task automatic scan(input logic [37:0] bits, input int len,
                        output logic [31:0] out, input bit push, input logic [31:0] pv);
        out = '0;
        cap = 1'b1;
        @(negedge clk);
        cap = 1'b0;
        for (int i = 0; i < len; i++) begin
            shf = 1'b1;
            tdi = bits[i];
            if (i < 32) out[i] = tdo;
            @(negedge clk);
        end
        shf = 1'b0;
        upd = 1'b1;
        nv  = push;
        nd  = pv;
        @(negedge clk);
        upd = 1'b0;
        nv  = 1'b0;
        last_job = job;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input bit good);
        logic [31:0] junk;
        scan(wr_frame(a, d, good), 38, junk, 1'b0, '0);
    endtask

    task automatic rd(input int a, output logic [31:0] v, input bit push, input logic [31:0] pv);
        logic [31:0] junk;
        scan(rd_frame(a, 1'b0, 1'b1), 6, junk, push, pv);
        scan('0, 32, v, 1'b0, '0);
    endtask

    task automatic push_nonce(input logic [31:0] v);
        nv = 1'b1;
        nd = v;
        @(negedge clk);
        nv = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int a = 0; a < 16; a++) expv[a] = (a == 13) ? 32'd200 : '0;
    endtask

    function automatic bit storage(input int a);
        return (a >= 1 && a <= 11) || a == 13;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] v;
        sel = 1'b1; cap = 1'b0; shf = 1'b0; upd = 1'b0; tdi = 1'b0;
        nv = 1'b0; nd = '0; last_job = 1'b0;
        @(negedge clk);
        do_reset();

        // R6: reset state
        chk("R6 clk_ctrl", clkc, 256'd200);
        chk("R6 midstate", mid, '0);
        chk("R6 tail", tail, '0);
        chk("R6 ovf", ovf, 0);
        chk("R11 idle job", job, 0);
        rd(13, v, 0, '0);
        chk("R6 R2 read clk", v, 256'd200);

        // R1 R7 R11: write every address with its own pattern
        for (int a = 0; a < 16; a++) begin
            logic [31:0] d = (32'h9E37_79B9 * (a + 1)) ^ (32'(a) << 28);
            wr(a, d, 1'b1);
            chk("R11 job pulse", last_job, (a == 11));
            if (storage(a)) expv[a] = d;
        end
        for (int k = 0; k < 8; k++) chk("R1 midstate port", mid[k*32 +: 32], expv[1+k]);
        for (int k = 0; k < 3; k++) chk("R1 tail port", tail[k*32 +: 32], expv[9+k]);
        chk("R1 clk port", clkc, expv[13]);

        // R2 R7 R8: read back all sixteen
        for (int a = 0; a < 16; a++) begin
            rd(a, v, 0, '0);
            if (a == 14) chk("R8 empty read", v, 32'hFFFF_FFFF);
            else         chk("R2 R7 readback", v, expv[a]);
        end

        // R3: bad parity write and job attempt
        wr(5, 32'h0BAD_0BAD, 1'b0);
        rd(5, v, 0, '0);
        chk("R3 bad parity write", v, expv[5]);
        wr(11, 32'h1234_5678, 1'b0);
        chk("R3 R11 bad parity no job", last_job, 0);
        chk("R3 tail unchanged", tail[64 +: 32], expv[11]);

        // R4: wrong lengths and wrong flag
        begin
            logic [31:0] junk;
            scan(wr_frame(2, 32'hAAAA_5555, 1'b1), 37, junk, 0, '0);
            scan(wr_frame(2, 32'hAAAA_5555, 1'b1), 39, junk, 0, '0);
            scan(rd_frame(2, 1'b1, 1'b1), 6, junk, 0, '0);
            begin
                logic [37:0] f = wr_frame(2, 32'h5555_AAAA, 1'b1);
                f[36] = 1'b0;
                f[37] = ~(^f[36:0]);
                scan(f, 38, junk, 0, '0);
            end
        end
        rd(2, v, 0, '0);
        chk("R4 length and flag", v, expv[2]);

        // R5: deselected scan
        sel = 1'b0;
        wr(3, 32'hDEAD_BEEF, 1'b1);
        sel = 1'b1;
        chk("R5 midstate word", mid[64 +: 32], expv[3]);
        rd(3, v, 0, '0);
        chk("R5 readback", v, expv[3]);

        // R7: write to result port does nothing visible
        push_nonce(32'hC0DE_0001);
        wr(14, 32'h0000_0000, 1'b1);
        rd(14, v, 0, '0);
        chk("R7 R8 result write ignored", v, 32'hC0DE_0001);

        // R9 R8: fill, overflow, drain
        for (int i = 0; i < 16; i++) push_nonce(32'hA500_0000 + i);
        chk("R9 no ovf at full", ovf, 0);
        push_nonce(32'hFFFF_0000);
        chk("R9 ovf set", ovf, 1);
        for (int i = 0; i < 16; i++) begin
            rd(14, v, 0, '0);
            chk("R8 R9 order", v, 32'hA500_0000 + i);
        end
        rd(14, v, 0, '0);
        chk("R8 R9 dropped value absent", v, 32'hFFFF_FFFF);
        chk("R9 ovf sticky", ovf, 1);

        do_reset();
        chk("R6 ovf cleared", ovf, 0);
        chk("R6 clk reset", clkc, 256'd200);

        // R10: push and pop together on a full queue
        for (int i = 0; i < 16; i++) push_nonce(32'hB700_0000 + i);
        rd(14, v, 1, 32'h5EED_0010);
        chk("R10 popped head", v, 32'hB700_0000);
        chk("R10 no ovf", ovf, 0);
        for (int i = 1; i < 16; i++) begin
            rd(14, v, 0, '0);
            chk("R10 remaining", v, 32'hB700_0000 + i);
        end
        rd(14, v, 0, '0);
        chk("R10 pushed kept", v, 32'h5EED_0010);
        rd(14, v, 0, '0);
        chk("R10 R8 then empty", v, 32'hFFFF_FFFF);
        chk("R10 ovf final", ovf, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule